// File: doc/BRIEF.md
# Bit Count and Half-Swap Unit

This unit performs four bit-manipulation operations on a 64-bit operand: a leading-bit count whose polarity (zeros or ones) and scan width (in bytes) are selectable, a population count of the whole operand, a masked half-exchange of the operand, and a bit-test that turns a memory operand and the accumulator into flag updates. It is the execution stage for those operations inside a processor datapath. Operand fetch and memory write-back belong to the surrounding pipeline.

One operation is accepted per clock when `in_valid` is high. All outputs are registered, so the result, the flag values and their write enables appear one cycle later together with `out_valid`. The write enables tell the register file which of the result, Z, N and V is updated. When no operation is issued, every enable is low.

Top module: `bitops_unit`

## Requirements
- R1: While and after a synchronous reset, before any operation is issued, `out_valid`, `res_we`, `z_we`, `n_we` and `v_we` are 0 and `result` is 0.
- R2: An operation issued with `in_valid` high shows its outputs and `out_valid`=1 on the next rising edge. A cycle with `in_valid` low gives `out_valid`=0 and all four write enables 0 on the next edge.
- R3: The operation select encodes 2'b00 = leading count, 2'b01 = population count, 2'b10 = half-swap and 2'b11 = bit-test.
- R4: For a leading count, the byte width is `size` limited to the range 1..8: a size of 0 counts as 1 and a size above 8 counts as 8. The scan width is the byte width times 8, and operand bits at or above the scan width are ignored.
- R5: A leading count returns the number of consecutive operand bits equal to `polarity`, starting at bit width−1 and moving toward bit 0. When every bit below the width equals the polarity, the result is the full width.
- R6: A leading count raises `res_we` and `z_we`, sets `flag_z` only when the count is 0, and keeps `n_we` and `v_we` low.
- R7: A population count returns the number of set bits in all 64 operand bits, raises `res_we`, and keeps all flag enables low.
- R8: A half-swap uses s = `size` limited to 1..7. With h = (s−1)×4, m = all-ones shifted right by (7−s)×8, lo = m>>h and hi = (m<<h)&m, the result is ((x>>h)&lo) | ((x<<h)&hi). It raises `res_we` and keeps all flag enables low.
- R9: A bit-test sets `flag_n` to operand bit 7, `flag_v` to operand bit 6 and `flag_z` to 1 exactly when operand AND accumulator is zero. It raises all three flag enables, keeps `res_we` low and drives `result` to 0.
- R10: The accumulator input does not affect leading-count, population-count or half-swap results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue an operation this cycle |
| op | input | 2 | Operation select (see R3) |
| polarity | input | 1 | Bit value counted by the leading count |
| size | input | 4 | Byte-width select for leading count and half-swap |
| operand | input | 64 | Main operand |
| acc | input | 64 | Accumulator value used as the bit-test mask |
| out_valid | output | 1 | Outputs below belong to an issued operation |
| result | output | 64 | Registered result |
| res_we | output | 1 | Result register write enable |
| flag_z | output | 1 | Zero flag value |
| z_we | output | 1 | Zero flag write enable |
| flag_n | output | 1 | Negative flag value |
| n_we | output | 1 | Negative flag write enable |
| flag_v | output | 1 | Overflow flag value |
| v_we | output | 1 | Overflow flag write enable |

## Verification
The width limit and the all-equal shortcut of the leading count act in the same cycle on the same operand. Operands carry bits above the selected width that disagree with the polarity, while every bit inside the width matches it, so a design that ignored the limit would stop the scan early. Such a design would return a count below the width, where a correct one returns exactly the width with Z clear. Leading counts and bit-tests are also issued on consecutive cycles to show that the Z value and its enable always belong to the operation just retired.

// File: rtl/bitops_pkg.sv
package bitops_pkg;
  typedef enum logic [1:0] {
    OP_LEAD = 2'b00,
    OP_POP  = 2'b01,
    OP_SWAP = 2'b10,
    OP_TEST = 2'b11
  } bop_e;
endpackage

// File: rtl/lead_counter.sv
module lead_counter #(
  parameter int DATA_W = 64,
  parameter int SIZE_W = 4,
  localparam int MAXB  = DATA_W / 8,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] operand,
  input  logic              pol,
  input  logic [SIZE_W-1:0] size,
  output logic [CNT_W-1:0]  count
);
  logic [CNT_W-1:0] width;
  logic             run;

  always_comb begin
    // byte width limited to 1..MAXB (R4)
    if (size == '0)
      width = CNT_W'(8);
    else if (int'(size) > MAXB)
      width = CNT_W'(MAXB * 8);
    else
      width = CNT_W'(int'(size) * 8);
  end

  // scan from the top of the window; an all-equal window yields width (R5)
  always_comb begin
    count = '0;
    run   = 1'b1;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (i < int'(width)) begin
        if (run && (operand[i] == pol))
          count = count + CNT_W'(1);
        else
          run = 1'b0;
      end
    end
  end
endmodule

// File: rtl/pop_counter.sv
module pop_counter #(
  parameter int DATA_W = 64,
  localparam int NB    = DATA_W / 8,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] operand,
  output logic [CNT_W-1:0]  count
);
  logic [3:0] byte_cnt [NB];

  for (genvar g = 0; g < NB; g++) begin : g_byte
    always_comb begin
      byte_cnt[g] = '0;
      for (int b = 0; b < 8; b++)
        byte_cnt[g] = byte_cnt[g] + {3'b000, operand[g*8+b]};
    end
  end

  always_comb begin
    count = '0;
    for (int k = 0; k < NB; k++)
      count = count + CNT_W'(byte_cnt[k]);
  end
endmodule

// File: rtl/half_swapper.sv
module half_swapper #(
  parameter int DATA_W = 64,
  parameter int SIZE_W = 4,
  localparam int MAXS  = DATA_W / 8 - 1
) (
  input  logic [DATA_W-1:0] operand,
  input  logic [SIZE_W-1:0] size,
  output logic [DATA_W-1:0] swapped
);
  int                s;
  int                half;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] lo_mask;
  logic [DATA_W-1:0] hi_mask;

  always_comb begin
    // size limited to 1..MAXS (R8)
    if (size == '0)
      s = 1;
    else if (int'(size) > MAXS)
      s = MAXS;
    else
      s = int'(size);
    half    = (s - 1) * 4;
    mask    = {DATA_W{1'b1}} >> ((MAXS - s) * 8);
    lo_mask = mask >> half;
    hi_mask = (mask << half) & mask;
    swapped = ((operand >> half) & lo_mask) | ((operand << half) & hi_mask);
  end
endmodule

// File: rtl/bitops_unit.sv
module bitops_unit #(
  parameter int DATA_W = 64,
  parameter int SIZE_W = 4,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        op,
  input  logic              polarity,
  input  logic [SIZE_W-1:0] size,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] acc,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              res_we,
  output logic              flag_z,
  output logic              z_we,
  output logic              flag_n,
  output logic              n_we,
  output logic              flag_v,
  output logic              v_we
);
  import bitops_pkg::*;

  bop_e              op_sel;
  logic [CNT_W-1:0]  lead_cnt;
  logic [CNT_W-1:0]  pop_cnt;
  logic [DATA_W-1:0] swap_val;

  logic [DATA_W-1:0] nx_result;
  logic              nx_res_we, nx_z, nx_z_we, nx_n, nx_n_we, nx_v, nx_v_we;

  assign op_sel = bop_e'(op);

  lead_counter #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) i_lead (
    .operand(operand), .pol(polarity), .size(size), .count(lead_cnt)
  );

  pop_counter #(.DATA_W(DATA_W)) i_pop (
    .operand(operand), .count(pop_cnt)
  );

  half_swapper #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) i_swap (
    .operand(operand), .size(size), .swapped(swap_val)
  );

  always_comb begin
    nx_result = '0;
    nx_res_we = 1'b0;
    nx_z      = 1'b0;
    nx_z_we   = 1'b0;
    nx_n      = 1'b0;
    nx_n_we   = 1'b0;
    nx_v      = 1'b0;
    nx_v_we   = 1'b0;
    if (in_valid) begin
      unique case (op_sel)
        OP_LEAD: begin
          nx_result = DATA_W'(lead_cnt);
          nx_res_we = 1'b1;
          nx_z      = (lead_cnt == '0);
          nx_z_we   = 1'b1;
        end
        OP_POP: begin
          nx_result = DATA_W'(pop_cnt);
          nx_res_we = 1'b1;
        end
        OP_SWAP: begin
          nx_result = swap_val;
          nx_res_we = 1'b1;
        end
        OP_TEST: begin
          nx_n    = operand[7];
          nx_v    = operand[6];
          nx_z    = ((operand & acc) == '0);
          nx_n_we = 1'b1;
          nx_v_we = 1'b1;
          nx_z_we = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      res_we    <= 1'b0;
      flag_z    <= 1'b0;
      z_we      <= 1'b0;
      flag_n    <= 1'b0;
      n_we      <= 1'b0;
      flag_v    <= 1'b0;
      v_we      <= 1'b0;
    end else begin
      out_valid <= in_valid;
      result    <= nx_result;
      res_we    <= nx_res_we;
      flag_z    <= nx_z;
      z_we      <= nx_z_we;
      flag_n    <= nx_n;
      n_we      <= nx_n_we;
      flag_v    <= nx_v;
      v_we      <= nx_v_we;
    end
  end

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && !res_we && !z_we && !n_we && !v_we);

  // R6
  lead_zflag_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b00) |=> z_we && res_we && !n_we && (flag_z == (result == '0)));

  // R7
  pop_value_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b01) |=> res_we && !z_we && (result == DATA_W'($countones($past(operand)))));

  // R8
  swap_noflag_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b10) |=> res_we && !z_we && !n_we && !v_we);

  // R9
  test_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b11) |=> !res_we && n_we && v_we
      && (flag_n == $past(operand[7])) && (flag_v == $past(operand[6])));

  // R5
  lead_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b00) |=> result <= DATA_W'(DATA_W));
endmodule

// File: tb/test_bitops_unit.sv
module test_bitops_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  op = 2'b00;
  logic        polarity = 1'b0;
  logic [3:0]  size = 4'd0;
  logic [63:0] operand = '0;
  logic [63:0] acc = '0;
  logic        out_valid, res_we, flag_z, z_we, flag_n, n_we, flag_v, v_we;
  logic [63:0] result;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bitops_unit i_bitops_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .polarity(polarity),
    .size(size), .operand(operand), .acc(acc), .out_valid(out_valid),
    .result(result), .res_we(res_we), .flag_z(flag_z), .z_we(z_we),
    .flag_n(flag_n), .n_we(n_we), .flag_v(flag_v), .v_we(v_we)
  );

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] lead_model(logic [63:0] x, logic p, int sz);
    int b = (sz == 0) ? 1 : ((sz > 8) ? 8 : sz);
    int n = 0;
    int i = b * 8 - 1;
    while (i >= 0 && x[i] == p) begin
      n++;
      i--;
    end
    return 64'(n);
  endfunction

  function automatic logic [63:0] pop_model(logic [63:0] x);
    int n = 0;
    for (int i = 0; i < 64; i++) if (x[i]) n++;
    return 64'(n);
  endfunction

  function automatic logic [63:0] swap_model(logic [63:0] x, int sz);
    int s = (sz == 0) ? 1 : ((sz > 7) ? 7 : sz);
    int h = (s - 1) * 4;
    logic [63:0] m = 64'hFFFF_FFFF_FFFF_FFFF >> ((7 - s) * 8);
    logic [63:0] lo = m >> h;
    logic [63:0] hi = (m << h) & m;
    return ((x >> h) & lo) | ((x << h) & hi);
  endfunction

  // drive at a falling edge, check at the next falling edge (one register)
  task automatic issue(string req, logic [1:0] o, logic p, logic [3:0] sz,
                       logic [63:0] x, logic [63:0] a);
    logic [63:0] exp;
    in_valid = 1'b1; op = o; polarity = p; size = sz; operand = x; acc = a;
    @(negedge clk);
    check(req, "out_valid", 64'(out_valid), 64'd1);
    case (o)
      2'b00: begin // R3 leading count
        exp = lead_model(x, p, int'(sz));
        check(req, "lead result", result, exp);
        check(req, "lead z", 64'(flag_z), 64'(exp == 0));
        check(req, "lead we", {60'd0, res_we, z_we, n_we, v_we}, 64'b1100);
      end
      2'b01: begin // R3 population count
        check(req, "pop result", result, pop_model(x));
        check(req, "pop we", {60'd0, res_we, z_we, n_we, v_we}, 64'b1000);
      end
      2'b10: begin // R3 half-swap
        check(req, "swap result", result, swap_model(x, int'(sz)));
        check(req, "swap we", {60'd0, res_we, z_we, n_we, v_we}, 64'b1000);
      end
      default: begin // R3 bit-test
        check(req, "test nvz", {61'd0, flag_n, flag_v, flag_z},
              {61'd0, x[7], x[6], ((x & a) == 0)});
        check(req, "test we", {60'd0, res_we, z_we, n_we, v_we}, 64'b0111);
        check(req, "test result", result, 64'd0);
      end
    endcase
  endtask

  task automatic t_reset();
    check("R1", "out_valid", 64'(out_valid), 64'd0);
    check("R1", "enables", {60'd0, res_we, z_we, n_we, v_we}, 64'd0);
    check("R1", "result", result, 64'd0);
  endtask

  task automatic t_idle();
    in_valid = 1'b0; op = 2'b11; operand = 64'hFF;
    @(negedge clk);
    check("R2", "idle out_valid", 64'(out_valid), 64'd0);
    check("R2", "idle enables", {60'd0, res_we, z_we, n_we, v_we}, 64'd0);
  endtask

  task automatic t_lead();
    issue("R5", 2'b00, 1'b0, 4'd8, 64'h0000_00F0_0000_0000, '0);
    issue("R5", 2'b01 ^ 2'b01, 1'b1, 4'd8, 64'hFFF0_0000_0000_0000, '0);
    // R6 count zero sets Z
    issue("R6", 2'b00, 1'b0, 4'd8, 64'h8000_0000_0000_0000, '0);
    // R4 width limit with foreign upper bits, all-equal window
    issue("R4", 2'b00, 1'b0, 4'd2, 64'hFFFF_FFFF_FFFF_0000, '0);
    issue("R4", 2'b00, 1'b1, 4'd2, 64'h0000_0000_0000_FFFF, '0);
    issue("R4", 2'b00, 1'b0, 4'd0, 64'h0000_0000_0000_0003, '0);
    issue("R4", 2'b00, 1'b0, 4'd13, 64'h0000_0000_0000_0100, '0);
    issue("R5", 2'b00, 1'b0, 4'd8, 64'd0, '0);
    issue("R5", 2'b00, 1'b1, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, '0);
    issue("R5", 2'b00, 1'b1, 4'd3, 64'h0000_0000_00FF_F0F0, '0);
    // R10 accumulator has no effect
    issue("R10", 2'b00, 1'b0, 4'd8, 64'h0000_0000_0001_0000, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_pop();
    issue("R7", 2'b01, 1'b0, 4'd0, 64'd0, '0);
    issue("R7", 2'b01, 1'b0, 4'd1, 64'hFFFF_FFFF_FFFF_FFFF, '0);
    issue("R7", 2'b01, 1'b1, 4'd3, 64'h8421_0F00_1234_5678, 64'hDEAD);
  endtask

  task automatic t_swap();
    issue("R8", 2'b10, 1'b0, 4'd7, 64'h0123_4567_89AB_CDEF, '0);
    issue("R8", 2'b10, 1'b0, 4'd3, 64'hFFFF_FFFF_1122_3344, '0);
    issue("R8", 2'b10, 1'b0, 4'd1, 64'hAAAA_BBBB_CCCC_DDEE, '0);
    issue("R8", 2'b10, 1'b0, 4'd0, 64'h1234_5678_9ABC_DEF0, '0);
    issue("R8", 2'b10, 1'b1, 4'd15, 64'hFEDC_BA98_7654_3210, '0);
    issue("R10", 2'b10, 1'b0, 4'd5, 64'h0F0E_0D0C_0B0A_0908, 64'h5555);
  endtask

  task automatic t_test();
    issue("R9", 2'b11, 1'b0, 4'd0, 64'h0000_0000_0000_00C0, 64'h0000_0000_0000_0003);
    issue("R9", 2'b11, 1'b0, 4'd0, 64'h0000_0000_0000_0081, 64'h0000_0000_0000_0001);
    issue("R9", 2'b11, 1'b0, 4'd0, 64'h8000_0000_0000_0040, 64'h8000_0000_0000_0000);
  endtask

  task automatic t_back_to_back();
    issue("R6", 2'b00, 1'b0, 4'd8, 64'h8000_0000_0000_0000, '0);
    issue("R9", 2'b11, 1'b0, 4'd0, 64'h0F, 64'hF0);
    issue("R6", 2'b00, 1'b1, 4'd1, 64'hFFFF_FFFF_FFFF_FF7F, '0);
    issue("R9", 2'b11, 1'b0, 4'd0, 64'h3F, 64'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_lead();
    t_idle();
    t_pop();
    t_swap();
    t_test();
    t_back_to_back();
    t_idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule